// File: doc/BRIEF.md
# Timer with PWM, compare and capture channels

This block is a 16-bit interval counter paced by a selectable source and a power-of-two prescaler. A set of channels shares the count. Each channel can latch the count on an input edge, toggle its pin when the count matches, or produce pulse-width modulation. The counter runs either up only (sawtooth) or up and down (triangle). The same channel setting therefore gives edge-aligned PWM with the sawtooth and center-aligned PWM with the triangle.

Software configures the block through a plain write port, one register per address. The final count and the compare values are double-buffered. A new value written while the counter runs takes effect only at the next counter reload, so a period or a pulse is never cut short. Overflow and per-channel events set sticky flags that serve as interrupt requests. Every overflow also emits a one-cycle trigger pulse for neighbouring logic.

All pins are plain control and status signals. The block has no streaming data path, so none of its ports carries a valid/ready handshake or back-pressure.

Top module: `tpwm_top`

## Requirements
- R1: After reset the count is 0, all channels are off with pins low, all flags are 0 and the trigger is low.
- R2: Address 0 bits [1:0] pick the count source. Value 0 (and 3) stops the counter, 1 advances it on every clock, and 2 advances it on each cycle in which `ext_tick` is high. A stopped counter holds its value.
- R3: Address 0 bits [4:2] hold n. The counter advances once per 2^n source events, with n from 0 to 7.
- R4: With address 0 bit 5 clear (up mode), the counter steps 0,1,..,F, where F is the final value written at address 1. On the step after reaching F (or any value above F), it returns to 0 and sets the overflow flag.
- R5: With bit 5 set (up-down mode), the counter rises to F, turns, and falls to 0. It turns up again on the step that leaves 0, which is the only step that sets the overflow flag. The period is 2F steps.
- R6: Final and compare values written while the counter runs take effect at the next overflow step. While the counter is stopped they take effect at once.
- R7: Channel mode 2 (PWM) in up mode drives the pin high while the count is below the compare value. Over one period of F+1 steps this gives C high steps, or F+1 steps when C exceeds F (100%), or none when C is 0.
- R8: Channel mode 2 in up-down mode gives center-aligned PWM. Over 2F steps the pin is high for 2C-1 steps, for 2F steps when C exceeds F, and never when C is 0.
- R9: Channel mode 1 toggles the pin and sets the channel flag on each step where the count equals the compare value.
- R10: Channel mode 0 latches the count into `cap_value` and sets the channel flag on a selected edge of the channel input. In the mode register, bit 2 selects the rising edge and bit 3 the falling edge. An edge that is not selected changes neither the captured value nor the flag.
- R11: Writing address 2 clears flags where the data has a 1: bit 0 is the overflow flag and bit 1+c is channel c. A new event in the same cycle wins over the clear.
- R12: Each overflow step produces exactly one cycle of `trig_pulse`, in the same cycle the overflow flag is set.

Channel c uses address 3+2c for its mode (bits [1:0]: 0 capture, 1 toggle, 2 PWM, 3 off; bits [3:2] edge select) and address 4+2c for its compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External count enable, one cycle per event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | CNT_W | Register write data |
| ch_in | input | NCH | Channel capture inputs |
| ch_out | output | NCH | Channel pins |
| cap_value | output | NCH*CNT_W | Captured count per channel, channel c at bits c*CNT_W |
| count_value | output | CNT_W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ch_flag | output | NCH | Sticky per-channel event flags |
| trig_pulse | output | 1 | One-cycle trigger on overflow |

## Verification
The bench builds the block with its defaults: a 16-bit count, two channels and a 3-bit prescale exponent. The 3-bit exponent puts the largest divide (128) within a short run. Two channels let one channel toggle or capture while the other keeps producing PWM, which exposes any cross-channel field decode error. Random final and compare values in both count directions are checked against duty counts computed by bench functions. Directed cases cover 0% and 100% duty, the top turn in up-down mode, a mid-period reload, and captures on selected and unselected edges.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic [1:0] {
    CH_CAPTURE = 2'd0,
    CH_TOGGLE  = 2'd1,
    CH_PWM     = 2'd2,
    CH_OFF     = 2'd3
  } ch_mode_e;

  typedef enum logic [1:0] {
    SRC_STOP = 2'd0,
    SRC_CLK  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_HOLD = 2'd3
  } src_sel_e;

  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_FINAL   = 1;
  localparam int unsigned REG_CLEAR   = 2;
  localparam int unsigned REG_CH_BASE = 3;
endpackage

// File: rtl/tpwm_prescale.sv
module tpwm_prescale
  import tpwm_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_sel_e        src_sel,
  input  logic            ext_tick,
  input  logic [PS_W-1:0] ps_exp,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic             src_en;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    unique case (src_sel)
      SRC_CLK: src_en = 1'b1;
      SRC_EXT: src_en = ext_tick;
      default: src_en = 1'b0;
    endcase
  end

  assign mask = ~({DIV_W{1'b1}} << ps_exp);
  assign tick = src_en && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (src_sel == SRC_STOP || src_sel == SRC_HOLD) begin
      div_q <= '0;
    end else if (src_en) begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: with a divide above one, two ticks never come back to back
  assert_no_double_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(ps_exp) != '0 && $stable(ps_exp) && $stable(src_sel)) |-> !tick);
endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             updown,
  input  logic [CNT_W-1:0] fin_shadow,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] fin_q,
  output logic             ovf_evt,
  output logic             reload
);
  logic [CNT_W-1:0] cnt_d;
  logic             down_q, down_d;

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = down_q;
    ovf_evt = 1'b0;
    if (tick) begin
      if (!updown) begin
        down_d = 1'b0;
        if (cnt_q >= fin_q) begin
          cnt_d   = '0;
          ovf_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (cnt_q >= fin_q) begin
          down_d = 1'b1;
          cnt_d  = (fin_q == '0) ? '0 : fin_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_d  = 1'b0;
          ovf_evt = 1'b1;
          cnt_d   = (fin_q == '0) ? '0 : CNT_W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  assign reload = ovf_evt || !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      fin_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      if (reload) fin_q <= fin_shadow;
    end
  end

  // R2: the count moves only on a prescaled tick
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt_q));
  // R4: in up mode a tick at or beyond the final value returns the count to zero
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !updown && cnt_q >= fin_q) |=> cnt_q == '0);
  // R6: the active final value changes only at a reload point
  assert_final_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fin_q) |-> $past(reload));
endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
  import tpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_mode_e         mode,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] cmp_shadow,
  input  logic             reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] fin_act,
  input  logic             pin_in,
  output logic             pin_out,
  output logic [CNT_W-1:0] cap_q,
  output logic             hit
);
  logic [CNT_W-1:0] cmp_q;
  logic             in_q;
  logic             rise, fall, cap_edge, match;

  assign rise     = pin_in & ~in_q;
  assign fall     = ~pin_in & in_q;
  assign cap_edge = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  assign match    = tick && (cnt == cmp_q);

  always_comb begin
    unique case (mode)
      CH_CAPTURE: hit = cap_edge;
      CH_TOGGLE,
      CH_PWM:     hit = match;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      in_q    <= 1'b0;
      pin_out <= 1'b0;
      cap_q   <= '0;
    end else begin
      in_q <= pin_in;
      if (reload) cmp_q <= cmp_shadow;
      unique case (mode)
        CH_CAPTURE: begin
          pin_out <= 1'b0;
          if (cap_edge) cap_q <= cnt;
        end
        CH_TOGGLE: if (match) pin_out <= ~pin_out;
        CH_PWM:    pin_out <= (cnt < cmp_q);
        default:   pin_out <= 1'b0;
      endcase
    end
  end

  // R10: the captured value moves only while the channel captures
  assert_capture_mode_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> $past(mode) == CH_CAPTURE);
  // R7: a compare value above the final value holds the pin high
  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_PWM && $past(mode) == CH_PWM && $past(cmp_q > fin_act)
     && $past(cnt <= fin_act)) |-> pin_out);
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
  import tpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 2,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_tick,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  input  logic [NCH-1:0]       ch_in,
  output logic [NCH-1:0]       ch_out,
  output logic [NCH*CNT_W-1:0] cap_value,
  output logic [CNT_W-1:0]     count_value,
  output logic                 ovf_flag,
  output logic [NCH-1:0]       ch_flag,
  output logic                 trig_pulse
);
  localparam int UD_BIT = 2 + PS_W;

  src_sel_e         src_q;
  logic [PS_W-1:0]  ps_q;
  logic             updown_q;
  logic [CNT_W-1:0] fin_sh_q;
  ch_mode_e         mode_q   [NCH];
  logic [1:0]       esel_q   [NCH];
  logic [CNT_W-1:0] cmp_sh_q [NCH];

  logic             tick, run, ovf_evt, reload, clr;
  logic [CNT_W-1:0] cnt, fin_act;
  logic [NCH-1:0]   hit;
  logic             ovf_q, trig_q;
  logic [NCH-1:0]   chf_q;

  assign run = (src_q == SRC_CLK) || (src_q == SRC_EXT);
  assign clr = reg_we && (reg_addr == ADDR_W'(REG_CLEAR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= SRC_STOP;
      ps_q     <= '0;
      updown_q <= 1'b0;
      fin_sh_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        mode_q[c]   <= CH_OFF;
        esel_q[c]   <= 2'b00;
        cmp_sh_q[c] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(REG_CTRL)) begin
        src_q    <= src_sel_e'(reg_wdata[1:0]);
        ps_q     <= reg_wdata[2 +: PS_W];
        updown_q <= reg_wdata[UD_BIT];
      end
      if (reg_addr == ADDR_W'(REG_FINAL)) fin_sh_q <= reg_wdata;
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == ADDR_W'(REG_CH_BASE + 2 * c)) begin
          mode_q[c] <= ch_mode_e'(reg_wdata[1:0]);
          esel_q[c] <= reg_wdata[3:2];
        end
        if (reg_addr == ADDR_W'(REG_CH_BASE + 2 * c + 1)) cmp_sh_q[c] <= reg_wdata;
      end
    end
  end

  tpwm_prescale #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_q),
    .ext_tick (ext_tick),
    .ps_exp   (ps_q),
    .tick     (tick)
  );

  tpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (run),
    .updown     (updown_q),
    .fin_shadow (fin_sh_q),
    .cnt_q      (cnt),
    .fin_q      (fin_act),
    .ovf_evt    (ovf_evt),
    .reload     (reload)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q[c]),
      .edge_sel   (esel_q[c]),
      .cmp_shadow (cmp_sh_q[c]),
      .reload     (reload),
      .tick       (tick),
      .cnt        (cnt),
      .fin_act    (fin_act),
      .pin_in     (ch_in[c]),
      .pin_out    (ch_out[c]),
      .cap_q      (cap_value[c*CNT_W +: CNT_W]),
      .hit        (hit[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      trig_q <= 1'b0;
      chf_q  <= '0;
    end else begin
      trig_q <= ovf_evt;
      ovf_q  <= ovf_evt | (ovf_q & ~(clr & reg_wdata[0]));
      for (int c = 0; c < NCH; c++)
        chf_q[c] <= hit[c] | (chf_q[c] & ~(clr & reg_wdata[1 + c]));
    end
  end

  assign count_value = cnt;
  assign ovf_flag    = ovf_q;
  assign ch_flag     = chf_q;
  assign trig_pulse  = trig_q;

  // R12: the trigger is always accompanied by the overflow flag
  assert_trig_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> ovf_q);
  // R5: in up-down mode the overflow flag rises only on leaving zero
  assert_zero_turn_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_q) && $past(updown_q)) |-> $past(cnt) == '0);
  // R11: a clear with no concurrent overflow drops the flag
  assert_clear_works_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && reg_wdata[0] && !ovf_evt) |=> !ovf_q);
endmodule

// File: tb/tb_tpwm_top.sv
module tb_tpwm_top;
  localparam int CNT_W = 16;
  localparam int NCH   = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 ext_tick = 1'b0;
  logic                 reg_we = 1'b0;
  logic [3:0]           reg_addr = '0;
  logic [CNT_W-1:0]     reg_wdata = '0;
  logic [NCH-1:0]       ch_in = '0;
  logic [NCH-1:0]       ch_out;
  logic [NCH*CNT_W-1:0] cap_value;
  logic [CNT_W-1:0]     count_value;
  logic                 ovf_flag;
  logic [NCH-1:0]       ch_flag;
  logic                 trig_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tpwm_top #(.CNT_W(CNT_W), .NCH(NCH), .PS_W(3), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ch_in(ch_in), .ch_out(ch_out),
    .cap_value(cap_value), .count_value(count_value), .ovf_flag(ovf_flag),
    .ch_flag(ch_flag), .trig_pulse(trig_pulse)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    reg_we    = 1'b1;
    reg_addr  = a[3:0];
    reg_wdata = d[CNT_W-1:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_ext(int n);
    repeat (n) begin
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic meas_high(int c, int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(ch_out[c]);
    end
  endtask

  function automatic int ctl(int src, int ps, int ud);
    return src | (ps << 2) | (ud << 5);
  endfunction

  function automatic int edge_duty(int cmp, int fin);
    return (cmp > fin) ? fin + 1 : cmp;
  endfunction

  function automatic int center_duty(int cmp, int fin);
    if (cmp == 0) return 0;
    if (cmp > fin) return 2 * fin;
    return 2 * cmp - 1;
  endfunction

  function automatic int cap_of(int c);
    return int'(cap_value[c*CNT_W +: CNT_W]);
  endfunction

  task automatic run_edge(int fin, int cmp, string req);
    int hi;
    wr(0, ctl(0, 0, 0));
    wr(1, fin);
    wr(3, 2);
    wr(4, cmp);
    wr(0, ctl(1, 0, 0));
    cyc(3 * (fin + 1) + 5);
    meas_high(0, fin + 1, hi);
    chk(req, hi, edge_duty(cmp, fin));
  endtask

  task automatic run_center(int fin, int cmp, string req);
    int hi;
    wr(0, ctl(0, 0, 1));
    wr(1, fin);
    wr(5, 2);
    wr(6, cmp);
    wr(0, ctl(1, 0, 1));
    cyc(6 * fin + 5);
    meas_high(1, 2 * fin, hi);
    chk(req, hi, center_duty(cmp, fin));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, mx, n, prev, tg, hi;
    void'($urandom(32'd7741));
    cyc(5);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 count", int'(count_value), 0);
    chk("R1 pins", int'(ch_out), 0);
    chk("R1 flags", int'({ovf_flag, ch_flag}), 0);
    chk("R1 trig", int'(trig_pulse), 0);

    // R2 stop, clock and external source
    wr(1, 100);
    cyc(20);
    chk("R2 stopped", int'(count_value), 0);
    wr(0, ctl(1, 0, 0));
    cyc(10);
    chk("R2 every clock", int'(count_value), 10);
    wr(0, ctl(0, 0, 0));
    cyc(5);
    chk("R2 hold", int'(count_value), 11);
    wr(0, ctl(2, 0, 0));
    pulse_ext(7);
    chk("R2 ext ticks", int'(count_value), 18);

    // R3 prescaler
    wr(0, ctl(0, 0, 0));
    wr(0, ctl(1, 3, 0));
    cyc(23);
    chk("R3 div8 early", int'(count_value), 20);
    cyc(1);
    chk("R3 div8", int'(count_value), 21);
    wr(0, ctl(0, 0, 0));
    c0 = int'(count_value);
    wr(0, ctl(1, 7, 0));
    cyc(384);
    chk("R3 div128", int'(count_value), c0 + 3);

    // R4 and R12 wrap in up mode
    wr(0, ctl(0, 0, 0));
    wr(1, 5);
    wr(2, 7);
    wr(0, ctl(1, 0, 0));
    cyc(1);
    chk("R4 wrap above final", int'(count_value), 0);
    chk("R4 overflow flag", int'(ovf_flag), 1);
    chk("R12 trig on wrap", int'(trig_pulse), 1);
    cyc(1);
    chk("R12 trig one cycle", int'(trig_pulse), 0);
    cyc(4);
    chk("R4 reaches final", int'(count_value), 5);
    cyc(1);
    chk("R4 wrap at final", int'(count_value), 0);
    tg = 0;
    repeat (60) begin
      @(negedge clk);
      tg += int'(trig_pulse);
    end
    chk("R12 trig count", tg, 10);

    // R11 flag clearing
    wr(0, ctl(0, 0, 0));
    wr(2, 0);
    chk("R11 zero write keeps flag", int'(ovf_flag), 1);
    wr(2, 1);
    chk("R11 clear overflow", int'(ovf_flag), 0);

    // R5 up-down turns
    wr(1, 10);
    wr(0, ctl(1, 0, 1));
    n = 0;
    while (count_value != 10 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R5 no flag at top", int'(ovf_flag), 0);
    cyc(1);
    chk("R5 turn at final", int'(count_value), 9);
    n = 0;
    while (count_value != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R5 no flag before zero turn", int'(ovf_flag), 0);
    cyc(1);
    chk("R5 turn at zero", int'(count_value), 1);
    chk("R5 flag at zero turn", int'(ovf_flag), 1);

    // R7 edge-aligned PWM, directed then random
    run_edge(7, 0, "R7 duty 0%");
    run_edge(7, 10, "R7 duty 100%");
    run_edge(7, 7, "R7 duty at final");
    for (int i = 0; i < 5; i++) begin
      int f, c;
      f = int'($urandom_range(40, 3));
      c = int'($urandom_range(f + 2, 0));
      run_edge(f, c, "R7 random duty");
    end

    // R8 center-aligned PWM, directed then random
    run_center(9, 0, "R8 duty 0%");
    run_center(9, 12, "R8 duty 100%");
    for (int i = 0; i < 5; i++) begin
      int f, c;
      f = int'($urandom_range(30, 2));
      c = int'($urandom_range(f + 1, 1));
      run_center(f, c, "R8 random duty");
    end

    // R6 buffered final and compare updates
    wr(0, ctl(0, 0, 0));
    wr(1, 20);
    wr(3, 2);
    wr(4, 10);
    wr(0, ctl(1, 0, 0));
    n = 0;
    while (count_value != 2 && n < 100) begin
      @(negedge clk);
      n++;
    end
    wr(1, 30);
    wr(4, 15);
    mx = 0;
    n = 0;
    while (count_value != 0 && n < 100) begin
      if (int'(count_value) > mx) mx = int'(count_value);
      @(negedge clk);
      n++;
    end
    chk("R6 old final kept", mx, 20);
    cyc(1);
    mx = 0;
    n = 0;
    while (count_value != 0 && n < 100) begin
      if (int'(count_value) > mx) mx = int'(count_value);
      @(negedge clk);
      n++;
    end
    chk("R6 new final used", mx, 30);
    meas_high(0, 31, hi);
    chk("R6 new compare used", hi, 15);

    // R9 output compare toggle
    wr(0, ctl(0, 0, 0));
    wr(1, 9);
    wr(5, 1);
    wr(6, 4);
    wr(2, 7);
    wr(0, ctl(1, 0, 0));
    cyc(12);
    chk("R9 flag on match", int'(ch_flag[1]), 1);
    tg = 0;
    prev = int'(ch_out[1]);
    repeat (50) begin
      @(negedge clk);
      if (int'(ch_out[1]) != prev) tg++;
      prev = int'(ch_out[1]);
    end
    chk("R9 toggles per period", tg, 5);

    // R10 capture with edge selection
    wr(0, ctl(0, 0, 0));
    wr(1, 200);
    wr(3, 8);
    wr(5, 3);
    wr(0, ctl(2, 0, 0));
    wr(2, 7);
    c0 = int'(count_value);
    ch_in[0] = 1'b1;
    cyc(2);
    chk("R10 rising ignored value", cap_of(0), 0);
    chk("R10 rising ignored flag", int'(ch_flag[0]), 0);
    pulse_ext(3);
    ch_in[0] = 1'b0;
    cyc(2);
    chk("R10 falling capture", cap_of(0), c0 + 3);
    chk("R10 capture flag", int'(ch_flag[0]), 1);
    wr(3, 12);
    pulse_ext(2);
    ch_in[0] = 1'b1;
    cyc(2);
    chk("R10 both edges capture", cap_of(0), c0 + 5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule